// File: doc/BRIEF.md
# Banked register file with stack

This block is the 128-byte internal data store of a small byte-oriented processor core. The same array serves three purposes. Its lowest 32 bytes hold four banks of eight working registers. An upward-growing stack, addressed by an 8-bit stack pointer, lives in the array. The remaining bytes are general storage, 20h to 2Fh and 30h to 7Fh, which this block treats as plain bytes.

Three clients share the array, and each has its own port. The core's register-number port names a register 0 to 7. The block maps it into the bank chosen by a 2-bit bank select input, at byte address bank×8 + number. A direct port reads and writes any byte by its 7-bit address. A stack port pushes and pops bytes and moves the pointer. Software can also load the pointer with a new value to move the stack away from the registers.

After reset the pointer holds 07h, so the first push lands on byte 08h. That byte is register 0 of bank 1, so by default the stack and bank 1 share storage. The core drives the bank select, and it is expected to present bank 0 after reset. All reads are combinational from the array. Writes take effect on the rising clock edge.

Top module: `bankreg_stack`

## Requirements
- R1: While and after reset (active-low `rst_n`), `sp_value` is 07h and `stack_err` is 0 when no stack strobe is active.
- R2: A register access with bank select b (0..3) and register number n (0..7) reads and writes byte address b×8 + n. Accesses to different banks do not disturb each other.
- R3: The direct port writes `dir_wdata` to byte `dir_addr` (00h..7Fh) on the clock edge when `dir_we` is 1. `dir_rdata` combinationally shows the byte at `dir_addr`.
- R4: A push adds one to the pointer and writes `push_data` at the new pointer value. After the edge, `pop_data` shows the pushed byte.
- R5: `pop_data` combinationally shows the byte at the current pointer. A pop subtracts one from the pointer on the edge.
- R6: When `sp_load` is 1, the pointer takes `sp_load_val` on the edge. Any push or pop in that cycle is ignored, and the push writes no byte.
- R7: When push and pop are requested in the same cycle, the push is performed and the pop is ignored.
- R8: A push whose new pointer would exceed 7Fh raises `stack_err` in that cycle and writes no byte, though the pointer still advances. A pop with the pointer above 7Fh raises `stack_err`. While the pointer is above 7Fh, `pop_data` reads 00h. Without a stack strobe, `stack_err` is 0.
- R9: When several writes hit one byte in a cycle, the push wins over the direct write, and the direct write wins over the register write.
- R10: With the reset pointer value, the first push writes byte 08h, which is register 0 of bank 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pointer |
| bank_sel | input | 2 | Bank used for register-number accesses |
| reg_idx | input | 3 | Register number within the bank |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dir_addr | input | 7 | Direct byte address |
| dir_we | input | 1 | Direct write strobe |
| dir_wdata | input | 8 | Direct write data |
| dir_rdata | output | 8 | Direct read data (combinational) |
| push_req | input | 1 | Push strobe |
| pop_req | input | 1 | Pop strobe |
| push_data | input | 8 | Byte to push |
| pop_data | output | 8 | Byte at the stack pointer, 00h when out of range |
| sp_load | input | 1 | Pointer load strobe |
| sp_load_val | input | 8 | New pointer value |
| sp_value | output | 8 | Current stack pointer |
| stack_err | output | 1 | Stack access outside the array this cycle |

## Verification
Push and pop can be requested in the same cycle. The bench provokes this while the stack holds two bytes and then checks that the pointer rose by one and that the top byte is the newly pushed one. A pointer load can coincide with a push, and the bench then checks that the pointer took the loaded value and that the byte the push would have written is unchanged. In a third collision, a push, a direct write and a register write all target byte 10h in one cycle. The direct read that follows must show the pushed byte, and later cycles drop the winners one by one.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
   // write ports of the array, index 0 has the highest priority
   localparam int WR_PORTS  = 3;
   localparam int WP_STACK  = 0;
   localparam int WP_DIRECT = 1;
   localparam int WP_REG    = 2;
   // read ports of the array
   localparam int RD_PORTS  = 3;
   localparam int RP_STACK  = 0;
   localparam int RP_DIRECT = 1;
   localparam int RP_REG    = 2;
endpackage

// File: rtl/bankreg_map.sv
module bankreg_map #(
   parameter int N_BANKS = 4,
   parameter int REGS    = 8,
   parameter int ADDR_W  = 7,
   localparam int BANK_W = $clog2(N_BANKS),
   localparam int IDX_W  = $clog2(REGS)
) (
   input  logic [BANK_W-1:0] bank,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   if (N_BANKS < 2 || (1 << BANK_W) != N_BANKS) begin : g_bad_banks
      $error("bankreg_map: N_BANKS must be a power of two of at least 2");
   end
   if (REGS < 2 || (1 << IDX_W) != REGS) begin : g_bad_regs
      $error("bankreg_map: REGS must be a power of two of at least 2");
   end
   if (BANK_W + IDX_W > ADDR_W) begin : g_bad_fit
      $error("bankreg_map: register banks do not fit the array");
   end

   if (BANK_W + IDX_W == ADDR_W) begin : g_exact
      assign addr = {bank, idx};
   end else begin : g_padded
      assign addr = {{(ADDR_W - BANK_W - IDX_W){1'b0}}, bank, idx};
   end
endmodule

// File: rtl/bankreg_sp.sv
module bankreg_sp #(
   parameter int SP_W     = 8,
   parameter int DEPTH    = 128,
   parameter int SP_RESET = 7,
   localparam int ADDR_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic              load,
   input  logic [SP_W-1:0]   load_val,
   output logic [SP_W-1:0]   sp,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_ok,
   output logic              err
);
   if (SP_W < ADDR_W) begin : g_bad_width
      $error("bankreg_sp: pointer narrower than the array address");
   end
   if (SP_RESET < 0 || SP_RESET >= (1 << SP_W)) begin : g_bad_reset
      $error("bankreg_sp: reset value does not fit the pointer");
   end

   logic            push_eff;
   logic            pop_eff;
   logic [SP_W:0]   sp_inc;
   logic            push_ok;
   logic            pop_ok;
   logic [SP_W-1:0] sp_next;

   // load overrides both strobes, push overrides pop
   assign push_eff = push & ~load;
   assign pop_eff  = pop & ~push & ~load;

   assign sp_inc  = (SP_W + 1)'(sp) + (SP_W + 1)'(1);
   assign push_ok = sp_inc < (SP_W + 1)'(DEPTH);
   assign pop_ok  = (SP_W + 1)'(sp) < (SP_W + 1)'(DEPTH);

   always_comb begin
      sp_next = sp;
      if (load)          sp_next = load_val;
      else if (push_eff) sp_next = sp_inc[SP_W-1:0];
      else if (pop_eff)  sp_next = sp - SP_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sp <= SP_W'(SP_RESET);
      else        sp <= sp_next;
   end

   assign wr_en   = push_eff & push_ok;
   assign wr_addr = sp_inc[ADDR_W-1:0];
   assign rd_addr = sp[ADDR_W-1:0];
   assign rd_ok   = pop_ok;
   assign err     = (push_eff & ~push_ok) | (pop_eff & ~pop_ok);
endmodule

// File: rtl/bankreg_ram.sv
module bankreg_ram #(
   parameter int DATA_W  = 8,
   parameter int DEPTH   = 128,
   parameter int N_WR    = 3,
   parameter int N_RD    = 3,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic                          clk,
   input  logic [N_WR-1:0]               wr_en,
   input  logic [N_WR-1:0][ADDR_W-1:0]   wr_addr,
   input  logic [N_WR-1:0][DATA_W-1:0]   wr_data,
   input  logic [N_RD-1:0][ADDR_W-1:0]   rd_addr,
   output logic [N_RD-1:0][DATA_W-1:0]   rd_data
);
   if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("bankreg_ram: DEPTH must be a power of two");
   end
   if (N_WR < 1 || N_RD < 1) begin : g_bad_ports
      $error("bankreg_ram: at least one read and one write port");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic              sel_en;
   logic [ADDR_W-1:0] sel_addr;
   logic [DATA_W-1:0] sel_data;

   // lowest-numbered active port wins
   always_comb begin
      sel_en   = 1'b0;
      sel_addr = '0;
      sel_data = '0;
      for (int i = N_WR - 1; i >= 0; i--) begin
         if (wr_en[i]) begin
            sel_en   = 1'b1;
            sel_addr = wr_addr[i];
            sel_data = wr_data[i];
         end
      end
   end

   // ports that collide on one byte are merged above; distinct bytes
   // written by losing ports are applied here as well
   always_ff @(posedge clk) begin
      for (int i = N_WR - 1; i >= 0; i--) begin
         if (wr_en[i] && !(sel_en && wr_addr[i] == sel_addr)) begin
            mem[wr_addr[i]] <= wr_data[i];
         end
      end
      if (sel_en) mem[sel_addr] <= sel_data;
   end

   for (genvar g = 0; g < N_RD; g++) begin : g_rd
      assign rd_data[g] = mem[rd_addr[g]];
   end
endmodule

// File: rtl/bankreg_stack.sv
module bankreg_stack
   import bankreg_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DEPTH    = 128,
   parameter int N_BANKS  = 4,
   parameter int REGS     = 8,
   parameter int SP_W     = 8,
   parameter int SP_RESET = 7,
   localparam int ADDR_W  = $clog2(DEPTH),
   localparam int BANK_W  = $clog2(N_BANKS),
   localparam int IDX_W   = $clog2(REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] bank_sel,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [ADDR_W-1:0] dir_addr,
   input  logic              dir_we,
   input  logic [DATA_W-1:0] dir_wdata,
   output logic [DATA_W-1:0] dir_rdata,
   input  logic              push_req,
   input  logic              pop_req,
   input  logic [DATA_W-1:0] push_data,
   output logic [DATA_W-1:0] pop_data,
   input  logic              sp_load,
   input  logic [SP_W-1:0]   sp_load_val,
   output logic [SP_W-1:0]   sp_value,
   output logic              stack_err
);
   logic [ADDR_W-1:0]                  reg_addr;
   logic                               stk_wr_en;
   logic [ADDR_W-1:0]                  stk_wr_addr;
   logic [ADDR_W-1:0]                  stk_rd_addr;
   logic                               stk_rd_ok;
   logic [WR_PORTS-1:0]                wr_en;
   logic [WR_PORTS-1:0][ADDR_W-1:0]    wr_addr;
   logic [WR_PORTS-1:0][DATA_W-1:0]    wr_data;
   logic [RD_PORTS-1:0][ADDR_W-1:0]    rd_addr;
   logic [RD_PORTS-1:0][DATA_W-1:0]    rd_data;

   bankreg_map #(
      .N_BANKS (N_BANKS),
      .REGS    (REGS),
      .ADDR_W  (ADDR_W)
   ) u_map (
      .bank (bank_sel),
      .idx  (reg_idx),
      .addr (reg_addr)
   );

   bankreg_sp #(
      .SP_W     (SP_W),
      .DEPTH    (DEPTH),
      .SP_RESET (SP_RESET)
   ) u_sp (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push_req),
      .pop      (pop_req),
      .load     (sp_load),
      .load_val (sp_load_val),
      .sp       (sp_value),
      .wr_en    (stk_wr_en),
      .wr_addr  (stk_wr_addr),
      .rd_addr  (stk_rd_addr),
      .rd_ok    (stk_rd_ok),
      .err      (stack_err)
   );

   always_comb begin
      wr_en[WP_STACK]    = stk_wr_en;
      wr_addr[WP_STACK]  = stk_wr_addr;
      wr_data[WP_STACK]  = push_data;
      wr_en[WP_DIRECT]   = dir_we;
      wr_addr[WP_DIRECT] = dir_addr;
      wr_data[WP_DIRECT] = dir_wdata;
      wr_en[WP_REG]      = reg_we;
      wr_addr[WP_REG]    = reg_addr;
      wr_data[WP_REG]    = reg_wdata;
      rd_addr[RP_STACK]  = stk_rd_addr;
      rd_addr[RP_DIRECT] = dir_addr;
      rd_addr[RP_REG]    = reg_addr;
   end

   bankreg_ram #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .N_WR   (WR_PORTS),
      .N_RD   (RD_PORTS)
   ) u_ram (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   assign pop_data  = stk_rd_ok ? rd_data[RP_STACK] : '0;
   assign dir_rdata = rd_data[RP_DIRECT];
   assign reg_rdata = rd_data[RP_REG];
endmodule

// File: rtl/bankreg_stack_chk.sv
module bankreg_stack_chk #(
   parameter int DATA_W   = 8,
   parameter int DEPTH    = 128,
   parameter int SP_W     = 8,
   parameter int SP_RESET = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_req,
   input logic              pop_req,
   input logic [DATA_W-1:0] push_data,
   input logic [DATA_W-1:0] pop_data,
   input logic              sp_load,
   input logic [SP_W-1:0]   sp_load_val,
   input logic [SP_W-1:0]   sp_value,
   input logic              stack_err
);
   localparam logic [SP_W-1:0] TOP = SP_W'(DEPTH - 1);

   AST_SP_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> sp_value == SP_W'(SP_RESET)); // R1
   AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      push_req && !pop_req && !sp_load |=> sp_value == $past(sp_value) + SP_W'(1)); // R4
   AST_PUSH_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      push_req && !sp_load && sp_value < TOP |=> pop_data == $past(push_data)); // R4
   AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      pop_req && !push_req && !sp_load |=> sp_value == $past(sp_value) - SP_W'(1)); // R5
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      sp_load |=> sp_value == $past(sp_load_val)); // R6
   AST_PUSH_OVER_POP: assert property (@(posedge clk) disable iff (!rst_n)
      push_req && pop_req && !sp_load |=> sp_value == $past(sp_value) + SP_W'(1)); // R7
   AST_PUSH_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      push_req && !sp_load && sp_value >= TOP |-> stack_err); // R8
   AST_POP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      sp_value > TOP |-> pop_data == '0); // R8
   AST_NO_SPURIOUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !push_req && !pop_req |-> !stack_err); // R8
endmodule

bind bankreg_stack bankreg_stack_chk #(
   .DATA_W   (DATA_W),
   .DEPTH    (DEPTH),
   .SP_W     (SP_W),
   .SP_RESET (SP_RESET)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .push_req    (push_req),
   .pop_req     (pop_req),
   .push_data   (push_data),
   .pop_data    (pop_data),
   .sp_load     (sp_load),
   .sp_load_val (sp_load_val),
   .sp_value    (sp_value),
   .stack_err   (stack_err)
);

// File: tb/sim_bankreg_stack.sv
`timescale 1ns/1ps
module sim_bankreg_stack;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bank_sel = '0;
   logic [2:0] reg_idx = '0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [6:0] dir_addr = '0;
   logic       dir_we = 1'b0;
   logic [7:0] dir_wdata = '0;
   logic [7:0] dir_rdata;
   logic       push_req = 1'b0;
   logic       pop_req = 1'b0;
   logic [7:0] push_data = '0;
   logic [7:0] pop_data;
   logic       sp_load = 1'b0;
   logic [7:0] sp_load_val = '0;
   logic [7:0] sp_value;
   logic       stack_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   bankreg_stack u0 (.*);

   // observed output selectors
   localparam int O_REG = 0, O_DIR = 1, O_POP = 2, O_SP = 3, O_ERR = 4;

   typedef struct {
      int         sel;
      logic [7:0] exp;
      string      tag;
   } exp_t;
   exp_t sb[$];

   task automatic expect_out(input int sel, input logic [7:0] exp, input string tag);
      exp_t e;
      e.sel = sel; e.exp = exp; e.tag = tag;
      sb.push_back(e);
   endtask

   function automatic logic [7:0] observe(input int sel);
      case (sel)
         O_REG:   return reg_rdata;
         O_DIR:   return dir_rdata;
         O_POP:   return pop_data;
         O_SP:    return sp_value;
         default: return {7'b0, stack_err};
      endcase
   endfunction

   // monitor: drains the scoreboard at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         while (sb.size() > 0) begin
            exp_t e;
            logic [7:0] act;
            e = sb.pop_front();
            act = observe(e.sel);
            checks++;
            if (act !== e.exp) begin
               errors++;
               $display("FAIL %s out=%0d act=%02h exp=%02h", e.tag, e.sel, act, e.exp);
            end
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic clear_strobes();
      reg_we = 1'b0; dir_we = 1'b0; push_req = 1'b0; pop_req = 1'b0; sp_load = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R1..all act=running exp=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      expect_out(O_SP, 8'h07, "R1 reset pointer");
      expect_out(O_ERR, 8'h00, "R1 reset error flag");
      tick();

      // R3 direct writes
      dir_we = 1'b1; dir_addr = 7'h7F; dir_wdata = 8'h81; tick();
      dir_addr = 7'h30; dir_wdata = 8'h42; tick();
      dir_addr = 7'h00; dir_wdata = 8'h5A; tick();
      clear_strobes();
      dir_addr = 7'h7F; expect_out(O_DIR, 8'h81, "R3 direct 7F"); tick();
      dir_addr = 7'h30; expect_out(O_DIR, 8'h42, "R3 direct 30"); tick();

      // R2 bank mapping
      bank_sel = 2'd2; reg_idx = 3'd5; reg_we = 1'b1; reg_wdata = 8'hA5; tick();
      clear_strobes();
      dir_addr = 7'h15;
      expect_out(O_DIR, 8'hA5, "R2 bank2 r5 at 15h");
      expect_out(O_REG, 8'hA5, "R2 bank2 r5 read");
      tick();
      bank_sel = 2'd0; reg_we = 1'b1; reg_wdata = 8'h3C; tick();
      clear_strobes();
      dir_addr = 7'h05;
      expect_out(O_REG, 8'h3C, "R2 bank0 r5 read");
      expect_out(O_DIR, 8'h3C, "R2 bank0 r5 at 05h");
      tick();
      bank_sel = 2'd2;
      expect_out(O_REG, 8'hA5, "R2 bank2 undisturbed");
      tick();

      // R4 / R10 first pushes
      push_req = 1'b1; push_data = 8'h11; tick();
      clear_strobes();
      bank_sel = 2'd1; reg_idx = 3'd0; dir_addr = 7'h08;
      expect_out(O_SP, 8'h08, "R4 pointer after push");
      expect_out(O_POP, 8'h11, "R4 top after push");
      expect_out(O_REG, 8'h11, "R10 first push is bank1 r0");
      expect_out(O_DIR, 8'h11, "R10 first push at 08h");
      tick();
      push_req = 1'b1; push_data = 8'h22; tick();
      clear_strobes();
      expect_out(O_SP, 8'h09, "R4 pointer second push");
      expect_out(O_POP, 8'h22, "R4 top second push");
      tick();

      // R7 push and pop together
      push_req = 1'b1; pop_req = 1'b1; push_data = 8'h33; tick();
      clear_strobes();
      dir_addr = 7'h09;
      expect_out(O_SP, 8'h0A, "R7 push wins pointer");
      expect_out(O_POP, 8'h33, "R7 push wins data");
      expect_out(O_DIR, 8'h22, "R7 lower byte kept");
      tick();

      // R5 pop
      pop_req = 1'b1;
      expect_out(O_POP, 8'h33, "R5 pop data before edge");
      tick();
      clear_strobes();
      expect_out(O_SP, 8'h09, "R5 pointer after pop");
      expect_out(O_POP, 8'h22, "R5 new top after pop");
      tick();

      // R6 load beats push
      sp_load = 1'b1; sp_load_val = 8'h7E; push_req = 1'b1; push_data = 8'h99; tick();
      clear_strobes();
      dir_addr = 7'h0A;
      expect_out(O_SP, 8'h7E, "R6 pointer loaded");
      expect_out(O_DIR, 8'h33, "R6 push ignored under load");
      tick();

      // R8 range boundary
      push_req = 1'b1; push_data = 8'h55;
      expect_out(O_ERR, 8'h00, "R8 push to 7F in range");
      tick();
      clear_strobes();
      dir_addr = 7'h7F;
      expect_out(O_SP, 8'h7F, "R8 pointer at top");
      expect_out(O_DIR, 8'h55, "R8 push to 7F stored");
      tick();
      push_req = 1'b1; push_data = 8'h66;
      expect_out(O_ERR, 8'h01, "R8 push beyond array flags");
      tick();
      clear_strobes();
      dir_addr = 7'h00;
      expect_out(O_SP, 8'h80, "R8 pointer advanced past top");
      expect_out(O_POP, 8'h00, "R8 out of range reads zero");
      expect_out(O_ERR, 8'h00, "R8 flag idle");
      expect_out(O_DIR, 8'h5A, "R8 dropped write");
      tick();
      pop_req = 1'b1;
      expect_out(O_ERR, 8'h01, "R8 pop out of range flags");
      expect_out(O_POP, 8'h00, "R8 pop data zero");
      tick();
      clear_strobes();
      expect_out(O_SP, 8'h7F, "R8 pointer back in range");
      expect_out(O_POP, 8'h55, "R8 top visible again");
      tick();

      // R9 write priority
      sp_load = 1'b1; sp_load_val = 8'h0F; tick();
      clear_strobes();
      push_req = 1'b1; push_data = 8'hC1;
      dir_we = 1'b1; dir_addr = 7'h10; dir_wdata = 8'hD2;
      reg_we = 1'b1; bank_sel = 2'd2; reg_idx = 3'd0; reg_wdata = 8'hE3;
      tick();
      clear_strobes();
      expect_out(O_DIR, 8'hC1, "R9 push beats others");
      expect_out(O_SP, 8'h10, "R9 pointer");
      tick();
      dir_we = 1'b1; reg_we = 1'b1; tick();
      clear_strobes();
      expect_out(O_DIR, 8'hD2, "R9 direct beats register");
      tick();
      reg_we = 1'b1; tick();
      clear_strobes();
      expect_out(O_REG, 8'hE3, "R9 register write alone");
      tick();

      tick();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule